// File: doc/BRIEF.md
# Debug Register-Access Command Engine

This block carries out register transfers that an external debugger requests through a small register bus. The debugger first loads up to four 32-bit message words, then writes a command word. The engine checks the command and, if it is acceptable, moves data between the message words and a target register-file port. It moves one 32-bit word per clock, starting with the least-significant word. A read command fills the message words from the target. A write command presents the message words to the target.

A control/status word reports a busy flag and a 3-bit error code. The error code is sticky: once it is set, every later command is dropped until the debugger clears the code by writing ones to it. The command is checked against a register-number map. The map separates integer registers, floating-point registers, one machine ISA register and a small window of read-only trace registers. Any other number is rejected.

Top module: `areg_engine`

## Requirements
- R1: After reset the status word reads 0 (busy clear, error code 0) and all four message words read 0.
- R2: Message words 0 to 3 are at bus addresses 0x04 to 0x07, with word 0 the least significant. A bus write stores into them and `bus_rdata` returns them. A bus write to them is ignored while busy.
- R3: The command word is at address 0x17. Bit 17 requests a transfer, bit 16 selects write (1) or read (0), bits 15:0 give the register number, and bits 22:20 give the size as log2 of its byte count: 2 means 1 word and 3 means 2 words. A read stays busy for one cycle per word and strobes the target once per word, word index ascending. Each returned word is stored into the message word of the same index, and message words above the transfer length are left unchanged.
- R4: A write command drives the message word of each index to `tgt_wdata`, with `tgt_write` high, one word per cycle.
- R5: A size code below 2, or one larger than log2(REG_WIDTH/8), sets error 2 and starts no transfer.
- R6: Register numbers 0x0301 and 0xC000 to 0xC007 are read-only: a write to them sets error 2, and a read from them works normally. A number outside the map (0x1000 to 0x103F, 0x0301, 0xC000 to 0xC007) sets error 2.
- R7: Integer register numbers 0x1000+n with n at or above NUM_INT_REGS set error 3 and start no transfer.
- R8: A command written while busy sets error 1 if the code is 0, leaves any other code unchanged, and does not disturb the running transfer.
- R9: While the error code is nonzero, a command starts no transfer and leaves the message words and the code unchanged.
- R10: The status word is at 0x16, with busy in bit 12 and the error code in bits 10:8. Writing it clears each error bit whose written bit is 1, and leaves bits written 0 unchanged.
- R11: Register 0x1000 (x0) never strobes the target. A write to it is discarded. A read from it loads zeros into the transferred message words.
- R12: A command with bit 17 clear performs no transfer and sets no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Register bus word address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data for `bus_addr` (combinational) |
| tgt_valid | output | 1 | Target access strobe, one cycle per word |
| tgt_write | output | 1 | Target access is a write |
| tgt_regno | output | 16 | Target register number |
| tgt_word | output | 2 | Index of the 32-bit word being moved |
| tgt_wdata | output | 32 | Word to be written into the target |
| tgt_rdata | input | 32 | Word returned by the target for `tgt_regno`/`tgt_word` |

## Verification
The bench issues a command while an earlier one is still moving words. A design that let that command restart would show extra target strobes or corrupted message words, and one that ignored it would leave the error code at 0. It clears the error code one bit at a time, which exposes a plain-write implementation. It also sends commands while an error is pending, and a design that failed to block them would strobe the target. Further directed cases cover x0 reads, which must produce zeros rather than target data, writes to the read-only window, and sizes just past the configured width. Randomized commands over every region of the map compare the error code, the strobe count and the message words against a bench model.

// File: rtl/areg_pkg.sv
package areg_pkg;
  localparam int MSG_WORDS = 4;
  localparam int WIDX_W    = 2;

  localparam logic [6:0] ADDR_DATA0 = 7'h04;
  localparam logic [6:0] ADDR_CSR   = 7'h16;
  localparam logic [6:0] ADDR_CMD   = 7'h17;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BUSY   = 3'd1,
    ERR_NOTSUP = 3'd2,
    ERR_EXCEPT = 3'd3,
    ERR_HALT   = 3'd4,
    ERR_BUS    = 3'd5,
    ERR_RSVD   = 3'd6,
    ERR_OTHER  = 3'd7
  } cmd_err_e;

  typedef enum logic [1:0] {
    RC_UNMAPPED,
    RC_ABSENT,
    RC_READONLY,
    RC_NORMAL
  } reg_class_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic              zeroFill;
    logic [WIDX_W-1:0] wordIdx;
    logic              busy;
  } dp_ctl_t;
endpackage

// File: rtl/areg_cmd_decode.sv
module areg_cmd_decode
  import areg_pkg::*;
#(
  parameter int REG_WIDTH    = 64,
  parameter int NUM_INT_REGS = 16,
  parameter bit HAS_FP       = 1'b1
) (
  input  logic [2:0]        sizeCode,
  input  logic              xferBit,
  input  logic [15:0]       regNum,
  input  logic              isWrite,
  output cmd_err_e          decodeErr,
  output logic              doTransfer,
  output logic [WIDX_W-1:0] lastWord,
  output logic              toZeroReg
);
  localparam int MAX_SIZE_CODE = $clog2(REG_WIDTH / 8);

  reg_class_e regClass;
  logic       sizeBad;

  always_comb begin
    regClass = RC_UNMAPPED;
    if (regNum[15:5] == 11'h080)
      regClass = (int'(regNum[4:0]) < NUM_INT_REGS) ? RC_NORMAL : RC_ABSENT;
    else if (regNum[15:5] == 11'h081)
      regClass = HAS_FP ? RC_NORMAL : RC_ABSENT;
    else if (regNum == 16'h0301)
      regClass = RC_READONLY;
    else if (regNum[15:3] == 13'h1800)
      regClass = RC_READONLY;
  end

  assign sizeBad = (sizeCode < 3'd2) || (int'(sizeCode) > MAX_SIZE_CODE);

  always_comb begin
    decodeErr = ERR_NONE;
    if (xferBit) begin
      if (sizeBad)                                    decodeErr = ERR_NOTSUP;
      else if (regClass == RC_UNMAPPED)               decodeErr = ERR_NOTSUP;
      else if (regClass == RC_ABSENT)                 decodeErr = ERR_EXCEPT;
      else if (regClass == RC_READONLY && isWrite)    decodeErr = ERR_NOTSUP;
    end
  end

  assign doTransfer = xferBit && (decodeErr == ERR_NONE);

  always_comb begin
    case (sizeCode)
      3'd3:    lastWord = 2'd1;
      3'd4:    lastWord = 2'd3;
      default: lastWord = 2'd0;
    endcase
  end

  assign toZeroReg = (regNum == 16'h1000);
endmodule

// File: rtl/areg_ctrl.sv
module areg_ctrl
  import areg_pkg::*;
#(
  parameter int REG_WIDTH    = 64,
  parameter int NUM_INT_REGS = 16,
  parameter bit HAS_FP       = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdWrite,
  input  logic [2:0]  cmdSize,
  input  logic        cmdXfer,
  input  logic        cmdIsWrite,
  input  logic [15:0] cmdRegNum,
  input  logic        csrWrite,
  input  logic [2:0]  csrClearBits,
  output dp_ctl_t     dpCtl,
  output logic        busy,
  output cmd_err_e    cmdErr,
  output logic        tgt_valid,
  output logic        tgt_write,
  output logic [15:0] tgt_regno,
  output logic [1:0]  tgt_word
);
  cmd_err_e          decErr;
  logic              decGo;
  logic [WIDX_W-1:0] decLast;
  logic              decZero;

  areg_cmd_decode #(
    .REG_WIDTH(REG_WIDTH), .NUM_INT_REGS(NUM_INT_REGS), .HAS_FP(HAS_FP)
  ) u_decode (
    .sizeCode(cmdSize), .xferBit(cmdXfer), .regNum(cmdRegNum),
    .isWrite(cmdIsWrite), .decodeErr(decErr), .doTransfer(decGo),
    .lastWord(decLast), .toZeroReg(decZero)
  );

  logic              busyQ;
  cmd_err_e          errQ;
  logic [WIDX_W-1:0] wordQ;
  logic [WIDX_W-1:0] lastQ;
  logic              writeQ;
  logic              zeroQ;
  logic [15:0]       regnoQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ  <= 1'b0;
      errQ   <= ERR_NONE;
      wordQ  <= '0;
      lastQ  <= '0;
      writeQ <= 1'b0;
      zeroQ  <= 1'b0;
      regnoQ <= '0;
    end else begin
      if (busyQ) begin
        wordQ <= wordQ + 1'b1;
        if (wordQ == lastQ) busyQ <= 1'b0;
      end
      if (cmdWrite) begin
        if (busyQ) begin
          if (errQ == ERR_NONE) errQ <= ERR_BUSY;
        end else if (errQ == ERR_NONE) begin
          if (decErr != ERR_NONE) begin
            errQ <= decErr;
          end else if (decGo) begin
            busyQ  <= 1'b1;
            wordQ  <= '0;
            lastQ  <= decLast;
            writeQ <= cmdIsWrite;
            zeroQ  <= decZero;
            regnoQ <= cmdRegNum;
          end
        end
      end else if (csrWrite) begin
        errQ <= cmd_err_e'(errQ & ~csrClearBits);
      end
    end
  end

  assign busy      = busyQ;
  assign cmdErr    = errQ;
  assign tgt_valid = busyQ && !zeroQ;
  assign tgt_write = writeQ;
  assign tgt_regno = regnoQ;
  assign tgt_word  = wordQ;

  assign dpCtl.capture  = busyQ && !writeQ;
  assign dpCtl.zeroFill = zeroQ;
  assign dpCtl.wordIdx  = wordQ;
  assign dpCtl.busy     = busyQ;
endmodule

// File: rtl/areg_datapath.sv
module areg_datapath
  import areg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dp_ctl_t     dpCtl,
  input  cmd_err_e    cmdErr,
  input  logic [6:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] tgt_rdata,
  output logic [31:0] tgt_wdata
);
  logic [31:0] msgQ [MSG_WORDS];

  for (genvar gi = 0; gi < MSG_WORDS; gi++) begin : g_msg
    localparam logic [6:0] MY_ADDR = 7'(ADDR_DATA0 + gi);
    always_ff @(posedge clk) begin
      if (!rst_n)
        msgQ[gi] <= '0;
      else if (dpCtl.capture && dpCtl.wordIdx == WIDX_W'(gi))
        msgQ[gi] <= dpCtl.zeroFill ? 32'h0 : tgt_rdata;
      else if (bus_wr && bus_addr == MY_ADDR && !dpCtl.busy)
        msgQ[gi] <= bus_wdata;
    end
  end

  assign tgt_wdata = msgQ[dpCtl.wordIdx];

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_addr == ADDR_CSR)
      bus_rdata = {19'h0, dpCtl.busy, 1'b0, cmdErr, 8'h0};
    else if (bus_addr[6:2] == ADDR_DATA0[6:2])
      bus_rdata = msgQ[bus_addr[1:0]];
  end
endmodule

// File: rtl/areg_engine.sv
module areg_engine
  import areg_pkg::*;
#(
  parameter int REG_WIDTH    = 64,
  parameter int NUM_INT_REGS = 16,
  parameter bit HAS_FP       = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tgt_valid,
  output logic        tgt_write,
  output logic [15:0] tgt_regno,
  output logic [1:0]  tgt_word,
  output logic [31:0] tgt_wdata,
  input  logic [31:0] tgt_rdata
);
  dp_ctl_t  dpCtl;
  logic     busy;
  cmd_err_e cmdErr;

  areg_ctrl #(
    .REG_WIDTH(REG_WIDTH), .NUM_INT_REGS(NUM_INT_REGS), .HAS_FP(HAS_FP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdWrite(bus_wr && bus_addr == ADDR_CMD),
    .cmdSize(bus_wdata[22:20]), .cmdXfer(bus_wdata[17]),
    .cmdIsWrite(bus_wdata[16]), .cmdRegNum(bus_wdata[15:0]),
    .csrWrite(bus_wr && bus_addr == ADDR_CSR),
    .csrClearBits(bus_wdata[10:8]),
    .dpCtl(dpCtl), .busy(busy), .cmdErr(cmdErr),
    .tgt_valid(tgt_valid), .tgt_write(tgt_write),
    .tgt_regno(tgt_regno), .tgt_word(tgt_word)
  );

  areg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtl(dpCtl), .cmdErr(cmdErr),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tgt_rdata(tgt_rdata), .tgt_wdata(tgt_wdata)
  );
endmodule

// File: rtl/areg_engine_chk.sv
module areg_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic        busy,
  input logic [2:0]  cmdErr,
  input logic        tgt_valid,
  input logic        tgt_write,
  input logic [15:0] tgt_regno,
  input logic [1:0]  tgt_word
);
  // words of one transfer move in ascending order
  p_word_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && $past(tgt_valid) |-> tgt_word == $past(tgt_word) + 2'd1);

  // register number held for the whole transfer
  p_regno_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(tgt_regno));

  // read-only window never receives a write
  p_ro_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && tgt_write |-> !(tgt_regno == 16'h0301 || tgt_regno[15:3] == 13'h1800));

  // collision during a transfer always leaves a nonzero code
  p_busy_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr && bus_addr == 7'h17 |=> cmdErr != 3'd0);

  // a transfer only starts from a clean error code
  p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmdErr) == 3'd0);

  // clearing with all ones empties the code
  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h16 && bus_wdata[10:8] == 3'b111 |=> cmdErr == 3'd0);

  // x0 is never strobed
  p_zero_reg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> tgt_regno != 16'h1000);
endmodule

bind areg_engine areg_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .busy(busy), .cmdErr(cmdErr),
  .tgt_valid(tgt_valid), .tgt_write(tgt_write),
  .tgt_regno(tgt_regno), .tgt_word(tgt_word)
);

// File: tb/test_areg_engine.sv
module test_areg_engine;
  localparam int TB_WIDTH = 64;
  localparam int TB_NINT  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tgt_valid, tgt_write;
  logic [15:0] tgt_regno;
  logic [1:0]  tgt_word;
  logic [31:0] tgt_wdata, tgt_rdata;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  areg_engine #(.REG_WIDTH(TB_WIDTH), .NUM_INT_REGS(TB_NINT), .HAS_FP(1'b1)) i_areg_engine (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_valid(tgt_valid),
    .tgt_write(tgt_write), .tgt_regno(tgt_regno), .tgt_word(tgt_word),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  function automatic logic [31:0] tgt_model(logic [15:0] r, logic [1:0] w);
    return {r, 8'h5A, 6'h0, w};
  endfunction

  always_comb tgt_rdata = tgt_model(tgt_regno, tgt_word);

  // target-side monitor
  int          strobeCnt = 0;
  logic [31:0] seenW [4];
  logic        seenWr [4];
  always @(negedge clk) begin
    if (rst_n && tgt_valid) begin
      seenW[tgt_word]  = tgt_wdata;
      seenWr[tgt_word] = tgt_write;
      strobeCnt++;
    end
  end

  function automatic logic [31:0] mk_cmd(logic [15:0] r, logic [2:0] sz, logic wr, logic xf);
    return {9'h0, sz, 2'b00, xf, wr, r};
  endfunction

  function automatic int n_words(logic [2:0] sz);
    return (sz == 3'd3) ? 2 : (sz == 3'd4) ? 4 : 1;
  endfunction

  function automatic logic [2:0] exp_err(logic [31:0] c);
    logic [15:0] r = c[15:0];
    logic [2:0]  sz = c[22:20];
    if (!c[17]) return 3'd0;
    if (sz < 3'd2 || (8 << sz) > TB_WIDTH) return 3'd2;
    if (r >= 16'h1000 && r <= 16'h101F) return (int'(r - 16'h1000) < TB_NINT) ? 3'd0 : 3'd3;
    if (r >= 16'h1020 && r <= 16'h103F) return 3'd0;
    if (r == 16'h0301 || (r >= 16'hC000 && r <= 16'hC007)) return c[16] ? 3'd2 : 3'd0;
    return 3'd2;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 12; i++) begin
      bus_read(7'h16, v);
      if (!v[12]) return;
    end
  endtask

  task automatic run_cmd(logic [31:0] c, output logic [2:0] err);
    logic [31:0] v;
    strobeCnt = 0;
    bus_write(7'h17, c);
    wait_idle();
    bus_read(7'h16, v);
    err = v[10:8];
  endtask

  task automatic load_msgs(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
    bus_write(7'h04, w0); bus_write(7'h05, w1);
    bus_write(7'h06, w2); bus_write(7'h07, w3);
  endtask

  task automatic get_msg(int i, output logic [31:0] d);
    bus_read(7'(4 + i), d);
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    logic [2:0]  e;
    logic [31:0] pre [4];
    void'($urandom(32'd20240609));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(7'h16, v); check("R1", "status", v, 32'h0);
    for (int i = 0; i < 4; i++) begin get_msg(i, v); check("R1", "msg", v, 32'h0); end

    // R2 message words
    load_msgs(32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003);
    get_msg(0, v); check("R2", "data0", v, 32'h1111_0000);
    get_msg(3, v); check("R2", "data3", v, 32'h4444_0003);

    // R3 64-bit read of x5
    run_cmd(mk_cmd(16'h1005, 3'd3, 1'b0, 1'b1), e);
    check("R3", "err", 32'(e), 32'h0);
    check("R3", "strobes", strobeCnt, 2);
    get_msg(0, v); check("R3", "data0", v, tgt_model(16'h1005, 2'd0));
    get_msg(1, v); check("R3", "data1", v, tgt_model(16'h1005, 2'd1));
    get_msg(2, v); check("R3", "data2 kept", v, 32'h3333_0002);

    // R3 32-bit read of f3
    run_cmd(mk_cmd(16'h1023, 3'd2, 1'b0, 1'b1), e);
    check("R3", "strobes32", strobeCnt, 1);
    get_msg(0, v); check("R3", "f3 data0", v, tgt_model(16'h1023, 2'd0));
    get_msg(1, v); check("R3", "f3 data1 kept", v, tgt_model(16'h1005, 2'd1));

    // R4 64-bit write of x7
    load_msgs(32'hCAFE_0001, 32'hBEEF_0002, 32'h0, 32'h0);
    run_cmd(mk_cmd(16'h1007, 3'd3, 1'b1, 1'b1), e);
    check("R4", "err", 32'(e), 32'h0);
    check("R4", "strobes", strobeCnt, 2);
    check("R4", "wdata0", seenW[0], 32'hCAFE_0001);
    check("R4", "wdata1", seenW[1], 32'hBEEF_0002);
    check("R4", "write flag", 32'(seenWr[1]), 32'h1);

    // R5 size too big and too small
    run_cmd(mk_cmd(16'h1001, 3'd4, 1'b0, 1'b1), e);
    check("R5", "size128 err", 32'(e), 32'h2);
    check("R5", "size128 strobes", strobeCnt, 0);

    // R9 commands blocked while error pending
    run_cmd(mk_cmd(16'h1005, 3'd3, 1'b0, 1'b1), e);
    check("R9", "err kept", 32'(e), 32'h2);
    check("R9", "strobes", strobeCnt, 0);
    get_msg(0, v); check("R9", "data0 kept", v, 32'hCAFE_0001);

    // R10 write-one-to-clear per bit
    bus_write(7'h16, 32'h0000_0000);
    bus_read(7'h16, v); check("R10", "zero write", 32'(v[10:8]), 32'h2);
    bus_write(7'h16, 32'h0000_0100);
    bus_read(7'h16, v); check("R10", "clear bit8", 32'(v[10:8]), 32'h2);
    bus_write(7'h16, 32'h0000_0200);
    bus_read(7'h16, v); check("R10", "clear bit9", 32'(v[10:8]), 32'h0);

    run_cmd(mk_cmd(16'h1001, 3'd1, 1'b0, 1'b1), e);
    check("R5", "size16 err", 32'(e), 32'h2);
    bus_write(7'h16, 32'h700);

    // R6 read-only and unmapped
    run_cmd(mk_cmd(16'h0301, 3'd3, 1'b1, 1'b1), e);
    check("R6", "misa write", 32'(e), 32'h2); check("R6", "misa write strobes", strobeCnt, 0);
    bus_write(7'h16, 32'h700);
    run_cmd(mk_cmd(16'h0301, 3'd3, 1'b0, 1'b1), e);
    check("R6", "misa read", 32'(e), 32'h0); check("R6", "misa read strobes", strobeCnt, 2);
    run_cmd(mk_cmd(16'hC003, 3'd2, 1'b1, 1'b1), e);
    check("R6", "trace write", 32'(e), 32'h2);
    bus_write(7'h16, 32'h700);
    run_cmd(mk_cmd(16'h2000, 3'd2, 1'b0, 1'b1), e);
    check("R6", "unmapped", 32'(e), 32'h2);
    bus_write(7'h16, 32'h700);

    // R7 absent integer registers
    run_cmd(mk_cmd(16'h1010, 3'd3, 1'b0, 1'b1), e);
    check("R7", "x16 err", 32'(e), 32'h3); check("R7", "x16 strobes", strobeCnt, 0);
    bus_write(7'h16, 32'h700);
    run_cmd(mk_cmd(16'h100F, 3'd3, 1'b0, 1'b1), e);
    check("R7", "x15 ok", 32'(e), 32'h0);

    // R11 x0
    load_msgs(32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD);
    run_cmd(mk_cmd(16'h1000, 3'd3, 1'b1, 1'b1), e);
    check("R11", "x0 write err", 32'(e), 32'h0); check("R11", "x0 write strobes", strobeCnt, 0);
    run_cmd(mk_cmd(16'h1000, 3'd3, 1'b0, 1'b1), e);
    check("R11", "x0 read strobes", strobeCnt, 0);
    get_msg(0, v); check("R11", "x0 data0", v, 32'h0);
    get_msg(1, v); check("R11", "x0 data1", v, 32'h0);
    get_msg(2, v); check("R11", "x0 data2 kept", v, 32'hCCCC_CCCC);

    // R12 no transfer bit
    run_cmd(mk_cmd(16'h1005, 3'd3, 1'b0, 1'b0), e);
    check("R12", "err", 32'(e), 32'h0); check("R12", "strobes", strobeCnt, 0);
    get_msg(0, v); check("R12", "data0 kept", v, 32'h0);

    // R8 command while busy
    strobeCnt = 0;
    bus_write(7'h17, mk_cmd(16'h1005, 3'd3, 1'b0, 1'b1));
    bus_write(7'h17, mk_cmd(16'h1009, 3'd3, 1'b0, 1'b1));
    wait_idle();
    bus_read(7'h16, v);
    check("R8", "busy err", 32'(v[10:8]), 32'h1);
    check("R8", "strobes", strobeCnt, 2);
    get_msg(1, v); check("R8", "data1", v, tgt_model(16'h1005, 2'd1));
    bus_write(7'h16, 32'h700);

    // randomized commands
    for (int it = 0; it < 60; it++) begin
      logic [15:0] r;
      logic [2:0]  sz;
      logic        wr, xf;
      int          nw, expStrobes;
      logic [2:0]  ee;
      case ($urandom_range(0, 6))
        0: r = 16'h1000;
        1: r = 16'h1000 + 16'($urandom_range(1, 15));
        2: r = 16'h1010 + 16'($urandom_range(0, 15));
        3: r = 16'h1020 + 16'($urandom_range(0, 31));
        4: r = 16'h0301;
        5: r = 16'hC000 + 16'($urandom_range(0, 7));
        default: r = 16'($urandom_range(16'h2000, 16'hBFFF));
      endcase
      sz = 3'($urandom_range(0, 5));
      wr = 1'($urandom_range(0, 1));
      xf = ($urandom_range(0, 7) != 0);
      for (int i = 0; i < 4; i++) pre[i] = $urandom;
      load_msgs(pre[0], pre[1], pre[2], pre[3]);
      c  = mk_cmd(r, sz, wr, xf);
      ee = exp_err(c);
      nw = n_words(sz);
      expStrobes = (ee == 3'd0 && xf && r != 16'h1000) ? nw : 0;
      run_cmd(c, e);
      check("R5/R6/R7", "rand err", 32'(e), 32'(ee));
      check("R3", "rand strobes", strobeCnt, expStrobes);
      if (ee == 3'd0 && xf) begin
        for (int i = 0; i < 4; i++) begin
          logic [31:0] expV;
          if (wr || i >= nw) expV = pre[i];
          else if (r == 16'h1000) expV = 32'h0;
          else expV = tgt_model(r, 2'(i));
          get_msg(i, v); check("R3", "rand msg", v, expV);
          if (wr && i < nw && r != 16'h1000) check("R4", "rand wdata", seenW[i], pre[i]);
        end
      end
      bus_write(7'h16, 32'h700);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule